// File: doc/BRIEF.md
# Call/Return Stack Frame Sequencer

This block carries out the four stack operations of a small processor: push, pop, call and return. It holds the instruction pointer (IP), stack pointer (SP) and frame pointer (FP) itself. It reaches memory through a single request/response port that moves one 64-bit little-endian word per access. The stack grows toward higher byte addresses. A call stores the old FP and then the return address, so the frame pointer ends up 16 below the new SP. A return recovers SP from FP and then unwinds those two words.

Commands enter on a valid/ready handshake. The sequencer raises `cmd_ready` only while idle. A command that is offered while an operation is in flight waits until the sequencer is idle again, and nothing of it is taken early. Memory requests use valid/ready in the same way. A request holds its address, direction, data and byte strobes unchanged until `mem_req_ready` accepts it. The sequencer then waits, for as long as needed, for one `mem_rsp_valid` beat. It always accepts that beat. Only one access is ever outstanding.

Top module: `stack_frame_seq`

## Requirements
- R1: After reset, IP, SP and FP hold their reset parameters, `done` and `mem_req_valid` are low and `cmd_ready` is high.
- R2: Push (`cmd_op`=0) writes `cmd_value` to the current SP and, once the write response arrives, raises SP by the operand size in bytes.
- R3: Pop (`cmd_op`=1) first lowers SP by the size, then reads at the new SP. `pop_data` is the low size bytes of the response, zero-extended.
- R4: Call (`cmd_op`=2) writes FP at SP, then `cmd_next_ip` at SP+8. It finishes with IP = `cmd_value`, SP = old SP+16 and FP = new SP-16.
- R5: Return (`cmd_op`=3) sets SP to FP+16. It then reads the word at SP-8 into IP and the word below it into FP, which leaves SP at the entry FP.
- R6: `cmd_size` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. Call and return always use 8. `mem_req_strb` has its low size bits set. Data is right-justified: byte k of the data belongs to address `mem_req_addr`+k.
- R7: A request stays valid and unchanged until it is accepted, only one access is outstanding, and any stall on ready or response only delays the result.
- R8: `done` is high for exactly one cycle, the cycle after the last register update, and IP, SP, FP and `pop_data` already show the final values in that cycle.
- R9: `cmd_ready` is low from acceptance until `done` has fallen. A command held valid during that time has no effect on requests or registers.
- R10: All SP and FP arithmetic wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and taking a command |
| cmd_op | input | 2 | 0 push, 1 pop, 2 call, 3 return |
| cmd_size | input | 2 | Push/pop size code (log2 of bytes) |
| cmd_value | input | 64 | Push value or call target |
| cmd_next_ip | input | 64 | Return address stored by call |
| done | output | 1 | One-cycle completion pulse |
| pop_data | output | 64 | Zero-extended result of the last pop |
| ip | output | 64 | Instruction pointer |
| sp | output | 64 | Stack pointer |
| fp | output | 64 | Frame pointer |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 64 | Byte address of first byte |
| mem_req_wdata | output | 64 | Right-justified write data |
| mem_req_strb | output | 8 | Byte enables, low bytes first |
| mem_rsp_valid | input | 1 | Response beat |
| mem_rsp_rdata | input | 64 | Read data, byte k from address+k |

## Verification
An SP that drifts inside the sequencer shows up at the ports on the very next memory request, as a wrong `mem_req_addr` or strobe pattern, before the operation even completes. A wrong step or state shows up as a missing or extra request in the current command, or as `done` arriving early, late or for two cycles. Because the frame words are read back by later returns, a corrupted call frame shows in IP and FP at the end of the matching return.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } sfs_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } sfs_state_e;
endpackage

// File: rtl/sfs_lane.sv
module sfs_lane #(
  parameter int XLEN = 64,
  parameter int SZ_W = 2
) (
  input  logic [SZ_W-1:0]   size_i,
  input  logic [XLEN-1:0]   wdata_i,
  input  logic [XLEN-1:0]   rdata_i,
  output logic [XLEN/8-1:0] strb_o,
  output logic [XLEN-1:0]   nbytes_o,
  output logic [XLEN-1:0]   wdata_o,
  output logic [XLEN-1:0]   rdata_o
);
  localparam int STRB_W = XLEN / 8;

  logic [XLEN-1:0] bmask;

  assign nbytes_o = XLEN'(1) << size_i;

  // one enable per byte lane; lanes below the byte count are active
  for (genvar g = 0; g < STRB_W; g++) begin : g_lane
    assign strb_o[g]        = (XLEN'(g) < nbytes_o);
    assign bmask[g*8 +: 8]  = {8{strb_o[g]}};
  end

  assign wdata_o = wdata_i & bmask;
  assign rdata_o = rdata_i & bmask;
endmodule

// File: rtl/sfs_regs.sv
module sfs_regs #(
  parameter int              XLEN     = 64,
  parameter logic [XLEN-1:0] IP_RESET = '0,
  parameter logic [XLEN-1:0] SP_RESET = '0,
  parameter logic [XLEN-1:0] FP_RESET = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ip_we,
  input  logic [XLEN-1:0] ip_d,
  input  logic            sp_we,
  input  logic [XLEN-1:0] sp_d,
  input  logic            fp_we,
  input  logic [XLEN-1:0] fp_d,
  output logic [XLEN-1:0] ip_q,
  output logic [XLEN-1:0] sp_q,
  output logic [XLEN-1:0] fp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q <= IP_RESET;
      sp_q <= SP_RESET;
      fp_q <= FP_RESET;
    end else begin
      if (ip_we) ip_q <= ip_d;
      if (sp_we) sp_q <= sp_d;
      if (fp_we) fp_q <= fp_d;
    end
  end
endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int SZ_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_op,
  input  logic [SZ_W-1:0] cmd_size,
  input  logic [XLEN-1:0] cmd_value,
  input  logic [XLEN-1:0] cmd_next_ip,
  output logic            done,
  output logic [XLEN-1:0] pop_data,
  input  logic [XLEN-1:0] sp_i,
  input  logic [XLEN-1:0] fp_i,
  output logic            ip_we,
  output logic [XLEN-1:0] ip_d,
  output logic            sp_we,
  output logic [XLEN-1:0] sp_d,
  output logic            fp_we,
  output logic [XLEN-1:0] fp_d,
  output logic [SZ_W-1:0] lane_size,
  output logic [XLEN-1:0] lane_wraw,
  input  logic [XLEN-1:0] lane_nbytes,
  input  logic [XLEN-1:0] lane_rdata,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [XLEN-1:0] mem_req_addr,
  input  logic            mem_rsp_valid
);
  localparam int              STRB_W  = XLEN / 8;
  localparam int              MAX_SZ  = $clog2(STRB_W);
  localparam logic [XLEN-1:0] WORD_B  = XLEN'(STRB_W);
  localparam logic [XLEN-1:0] FRAME_B = XLEN'(2 * STRB_W);

  sfs_state_e      state_q;
  sfs_op_e         op_q;
  logic [SZ_W-1:0] size_q;
  logic [XLEN-1:0] val_q;
  logic [XLEN-1:0] nip_q;
  logic            step_q;
  logic            is_read;
  logic            is_last;

  assign cmd_ready     = (state_q == ST_IDLE);
  assign done          = (state_q == ST_DONE);
  assign mem_req_valid = (state_q == ST_REQ);
  assign is_read       = (op_q == OP_POP) || (op_q == OP_RET);
  assign is_last       = (op_q == OP_PUSH) || (op_q == OP_POP) || step_q;
  assign mem_req_write = !is_read;

  // frame words always move as full words
  assign lane_size = ((op_q == OP_CALL) || (op_q == OP_RET)) ? SZ_W'(MAX_SZ) : size_q;
  assign lane_wraw = (op_q == OP_CALL) ? (step_q ? nip_q : fp_i) : val_q;

  always_comb begin
    if (is_read) mem_req_addr = sp_i - lane_nbytes;
    else         mem_req_addr = sp_i;
  end

  always_comb begin
    ip_we = 1'b0; ip_d = '0;
    sp_we = 1'b0; sp_d = '0;
    fp_we = 1'b0; fp_d = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid && (sfs_op_e'(cmd_op) == OP_RET)) begin
          sp_we = 1'b1;
          sp_d  = fp_i + FRAME_B;
        end
      end
      ST_REQ: begin
        // reads lower SP when the request is taken
        if (mem_req_ready && is_read) begin
          sp_we = 1'b1;
          sp_d  = mem_req_addr;
        end
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          unique case (op_q)
            OP_PUSH: begin
              sp_we = 1'b1;
              sp_d  = sp_i + lane_nbytes;
            end
            OP_CALL: begin
              sp_we = 1'b1;
              sp_d  = sp_i + WORD_B;
              if (step_q) begin
                ip_we = 1'b1;
                ip_d  = val_q;
                fp_we = 1'b1;
                fp_d  = sp_i + WORD_B - FRAME_B;
              end
            end
            OP_RET: begin
              if (!step_q) begin
                ip_we = 1'b1;
                ip_d  = lane_rdata;
              end else begin
                fp_we = 1'b1;
                fp_d  = lane_rdata;
              end
            end
            default: ;
          endcase
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_PUSH;
      size_q   <= '0;
      val_q    <= '0;
      nip_q    <= '0;
      step_q   <= 1'b0;
      pop_data <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q    <= sfs_op_e'(cmd_op);
            size_q  <= cmd_size;
            val_q   <= cmd_value;
            nip_q   <= cmd_next_ip;
            step_q  <= 1'b0;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (op_q == OP_POP) pop_data <= lane_rdata;
            if (is_last) begin
              state_q <= ST_DONE;
            end else begin
              step_q  <= 1'b1;
              state_q <= ST_REQ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: completion pulse lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: an offered request is held steady until taken
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  // R3: taking a pop read lowers SP by the operand size
  a_r3_pop_lowers_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && (op_q == OP_POP)) |=>
      (sp_i == $past(sp_i) - $past(lane_nbytes)));

  // R2: a push response raises SP by the operand size
  a_r2_push_raises_sp: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAIT) && mem_rsp_valid && (op_q == OP_PUSH)) |=>
      (sp_i == $past(sp_i) + $past(lane_nbytes)));

  // R4: a finished call leaves FP two words below SP
  a_r4_call_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == OP_CALL)) |-> (fp_i == sp_i - FRAME_B));
endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq #(
  parameter int              XLEN     = 64,
  parameter logic [XLEN-1:0] IP_RESET = '0,
  parameter logic [XLEN-1:0] SP_RESET = XLEN'(64'h1000),
  parameter logic [XLEN-1:0] FP_RESET = XLEN'(64'h1000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [1:0]        cmd_size,
  input  logic [XLEN-1:0]   cmd_value,
  input  logic [XLEN-1:0]   cmd_next_ip,
  output logic              done,
  output logic [XLEN-1:0]   pop_data,
  output logic [XLEN-1:0]   ip,
  output logic [XLEN-1:0]   sp,
  output logic [XLEN-1:0]   fp,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [XLEN-1:0]   mem_req_addr,
  output logic [XLEN-1:0]   mem_req_wdata,
  output logic [XLEN/8-1:0] mem_req_strb,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_rdata
);
  localparam int SZ_W = 2;

  logic            ip_we, sp_we, fp_we;
  logic [XLEN-1:0] ip_d, sp_d, fp_d;
  logic [SZ_W-1:0] lane_size;
  logic [XLEN-1:0] lane_wraw, lane_nbytes, lane_rdata;

  sfs_regs #(
    .XLEN(XLEN), .IP_RESET(IP_RESET), .SP_RESET(SP_RESET), .FP_RESET(FP_RESET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ip_we(ip_we), .ip_d(ip_d),
    .sp_we(sp_we), .sp_d(sp_d),
    .fp_we(fp_we), .fp_d(fp_d),
    .ip_q(ip), .sp_q(sp), .fp_q(fp)
  );

  sfs_lane #(.XLEN(XLEN), .SZ_W(SZ_W)) u_lane (
    .size_i(lane_size), .wdata_i(lane_wraw), .rdata_i(mem_rsp_rdata),
    .strb_o(mem_req_strb), .nbytes_o(lane_nbytes),
    .wdata_o(mem_req_wdata), .rdata_o(lane_rdata)
  );

  sfs_ctrl #(.XLEN(XLEN), .SZ_W(SZ_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_size(cmd_size), .cmd_value(cmd_value), .cmd_next_ip(cmd_next_ip),
    .done(done), .pop_data(pop_data),
    .sp_i(sp), .fp_i(fp),
    .ip_we(ip_we), .ip_d(ip_d), .sp_we(sp_we), .sp_d(sp_d),
    .fp_we(fp_we), .fp_d(fp_d),
    .lane_size(lane_size), .lane_wraw(lane_wraw),
    .lane_nbytes(lane_nbytes), .lane_rdata(lane_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid)
  );

  // R6: strobes are a non-empty run starting at byte 0
  a_r6_strb_low_run: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ((mem_req_strb != '0) &&
                       (((mem_req_strb + 1'b1) & mem_req_strb) == '0)));
endmodule

// File: tb/stack_frame_seq_test.sv
module stack_frame_seq_test;
  localparam logic [63:0] IP_RST = 64'h0;
  localparam logic [63:0] SP_RST = 64'h40;
  localparam logic [63:0] FP_RST = 64'h30;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  sz;
    logic [63:0] val;
    logic [63:0] nip;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd3, 64'h1122334455667788, 64'h0},
    '{2'd0, 2'd0, 64'hFFFFFFFFFFFFFFA5, 64'h0},
    '{2'd0, 2'd1, 64'h123456789ABCBEEF, 64'h0},
    '{2'd2, 2'd3, 64'h1000, 64'h2222},
    '{2'd0, 2'd2, 64'h77777777CAFEF00D, 64'h0},
    '{2'd1, 2'd2, 64'h0, 64'h0},
    '{2'd2, 2'd0, 64'h3000, 64'h4444},
    '{2'd3, 2'd0, 64'h0, 64'h0},
    '{2'd3, 2'd0, 64'h0, 64'h0},
    '{2'd1, 2'd1, 64'h0, 64'h0},
    '{2'd1, 2'd0, 64'h0, 64'h0},
    '{2'd1, 2'd3, 64'h0, 64'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [1:0]  cmd_size = 2'd0;
  logic [63:0] cmd_value = '0;
  logic [63:0] cmd_next_ip = '0;
  logic        done;
  logic [63:0] pop_data, ip, sp, fp;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [63:0] mem_req_addr, mem_req_wdata;
  logic [7:0]  mem_req_strb;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_rdata = '0;

  always #10 clk = ~clk;

  stack_frame_seq #(.XLEN(64), .IP_RESET(IP_RST), .SP_RESET(SP_RST), .FP_RESET(FP_RST)) uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_size(cmd_size), .cmd_value(cmd_value), .cmd_next_ip(cmd_next_ip),
    .done(done), .pop_data(pop_data), .ip(ip), .sp(sp), .fp(fp),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_strb(mem_req_strb),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  // memory seen by the design, and the bench's own shadow of it
  logic [7:0] mem [256];
  logic [7:0] sh  [256];

  // responder knobs and request log
  int ready_delay = 0;
  int rsp_delay = 0;
  int lg_n = 0;
  logic        lg_w [4];
  logic [63:0] lg_a [4];
  logic [63:0] lg_d [4];
  logic [7:0]  lg_s [4];

  // expected log and model registers
  int ex_n = 0;
  logic        ex_w [4];
  logic [63:0] ex_a [4];
  logic [63:0] ex_d [4];
  logic [7:0]  ex_s [4];
  logic [63:0] m_ip = IP_RST;
  logic [63:0] m_sp = SP_RST;
  logic [63:0] m_fp = FP_RST;
  logic [63:0] e_pop = '0;
  int last_cyc = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] bytemask(input logic [7:0] s);
    logic [63:0] m;
    for (int k = 0; k < 8; k++) m[k*8 +: 8] = {8{s[k]}};
    return m;
  endfunction

  function automatic logic [7:0] strb_of(input int nb);
    return 8'((9'd1 << nb) - 9'd1);
  endfunction

  task automatic sh_write(input logic [63:0] a, input logic [63:0] d, input int nb);
    for (int k = 0; k < nb; k++) sh[8'(a + 64'(k))] = d[k*8 +: 8];
  endtask

  function automatic logic [63:0] sh_read(input logic [63:0] a);
    logic [63:0] d;
    for (int k = 0; k < 8; k++) d[k*8 +: 8] = sh[8'(a + 64'(k))];
    return d;
  endfunction

  task automatic ex_add(input logic w, input logic [63:0] a, input logic [7:0] s,
                        input logic [63:0] d);
    if (ex_n < 4) begin
      ex_w[ex_n] = w; ex_a[ex_n] = a; ex_s[ex_n] = s; ex_d[ex_n] = d;
    end
    ex_n++;
  endtask

  // memory responder: inputs change on the falling edge only
  initial begin
    int rdy_cnt;
    int rsp_cnt;
    bit pend;
    logic        cw;
    logic [63:0] ca, cd, rd;
    logic [7:0]  cs;
    rdy_cnt = 0; rsp_cnt = 0; pend = 0;
    cw = 0; ca = '0; cd = '0; cs = '0; rd = '0;
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        pend = 1; rsp_cnt = rsp_delay;
        if (lg_n < 4) begin
          lg_w[lg_n] = cw; lg_a[lg_n] = ca; lg_d[lg_n] = cd; lg_s[lg_n] = cs;
        end
        lg_n++;
        for (int k = 0; k < 8; k++) begin
          if (cw && cs[k]) mem[8'(ca + 64'(k))] = cd[k*8 +: 8];
          rd[k*8 +: 8] = mem[8'(ca + 64'(k))];
        end
      end else if (mem_req_valid && !pend && !mem_rsp_valid) begin
        if (rdy_cnt >= ready_delay) begin
          mem_req_ready = 1'b1;
          cw = mem_req_write; ca = mem_req_addr; cd = mem_req_wdata; cs = mem_req_strb;
          rdy_cnt = 0;
        end else begin
          rdy_cnt++;
        end
      end
      if (pend) begin
        if (rsp_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = cw ? ~rd : rd;
          pend = 0;
        end else begin
          rsp_cnt--;
        end
      end
    end
  end

  task automatic run_cmd(input logic [1:0] op, input logic [1:0] sz,
                         input logic [63:0] val, input logic [63:0] nip, input bit hold);
    string rq;
    int nb;
    bit busy_bad;
    int cyc;
    nb = 1 << sz;
    ex_n = 0;
    case (op)
      2'd0: begin
        rq = "R2";
        ex_add(1'b1, m_sp, strb_of(nb), val);
        sh_write(m_sp, val, nb);
        m_sp = m_sp + 64'(nb);
      end
      2'd1: begin
        rq = "R3";
        m_sp = m_sp - 64'(nb);
        ex_add(1'b0, m_sp, strb_of(nb), 64'h0);
        e_pop = sh_read(m_sp) & bytemask(strb_of(nb));
      end
      2'd2: begin
        rq = "R4";
        ex_add(1'b1, m_sp, 8'hFF, m_fp);
        sh_write(m_sp, m_fp, 8);
        m_sp = m_sp + 64'd8;
        ex_add(1'b1, m_sp, 8'hFF, nip);
        sh_write(m_sp, nip, 8);
        m_sp = m_sp + 64'd8;
        m_ip = val;
        m_fp = m_sp - 64'd16;
      end
      default: begin
        rq = "R5";
        m_sp = m_fp + 64'd16;
        m_sp = m_sp - 64'd8;
        ex_add(1'b0, m_sp, 8'hFF, 64'h0);
        m_ip = sh_read(m_sp);
        m_sp = m_sp - 64'd8;
        ex_add(1'b0, m_sp, 8'hFF, 64'h0);
        m_fp = sh_read(m_sp);
      end
    endcase
    lg_n = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_size = sz;
    cmd_value = val; cmd_next_ip = nip;
    @(negedge clk);
    if (hold) begin
      cmd_op = 2'd3; cmd_value = 64'hDEAD; cmd_size = 2'd1;
    end else begin
      cmd_valid = 1'b0;
    end
    busy_bad = 0; cyc = 0;
    while (!done && cyc < 2000) begin
      if (cmd_ready) busy_bad = 1;
      @(negedge clk);
      cyc++;
    end
    last_cyc = cyc;
    if (cmd_ready) busy_bad = 1;
    cmd_valid = 1'b0;
    chk("R8", "done seen", 64'(done), 64'h1);
    chk(rq, "request count", 64'(lg_n), 64'(ex_n));
    for (int i = 0; i < ex_n && i < 4 && i < lg_n; i++) begin
      chk(rq, "request direction", 64'(lg_w[i]), 64'(ex_w[i]));
      chk(rq, "request address", lg_a[i], ex_a[i]);
      chk("R6", "request strobes", 64'(lg_s[i]), 64'(ex_s[i]));
      if (ex_w[i])
        chk("R6", "write data", lg_d[i] & bytemask(lg_s[i]), ex_d[i] & bytemask(ex_s[i]));
    end
    chk(rq, "ip", ip, m_ip);
    chk(rq, "sp", sp, m_sp);
    chk(rq, "fp", fp, m_fp);
    if (op == 2'd1) chk("R3", "pop_data", pop_data, e_pop);
    chk("R9", "cmd_ready low while busy", 64'(busy_bad), 64'h0);
    @(negedge clk);
    chk("R8", "done falls after one cycle", 64'(done), 64'h0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 11);
      sh[i]  = 8'(i * 37 + 11);
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset ip", ip, IP_RST);
    chk("R1", "reset sp", sp, SP_RST);
    chk("R1", "reset fp", fp, FP_RST);
    chk("R1", "reset done", 64'(done), 64'h0);
    chk("R1", "reset mem_req_valid", 64'(mem_req_valid), 64'h0);
    chk("R1", "reset cmd_ready", 64'(cmd_ready), 64'h1);

    for (int v = 0; v < NV; v++)
      run_cmd(VECS[v].op, VECS[v].sz, VECS[v].val, VECS[v].nip, 1'b0);

    // R9: a second command held valid during a push is not taken
    run_cmd(2'd0, 2'd2, 64'h0BADF00D, 64'h0, 1'b1);
    run_cmd(2'd1, 2'd2, 64'h0, 64'h0, 1'b1);

    // R7: long stalls on ready and response only delay the results
    ready_delay = 7; rsp_delay = 9;
    run_cmd(2'd0, 2'd3, 64'hA1B2C3D4E5F60718, 64'h0, 1'b0);
    chk("R7", "push stall lengthens operation", 64'(last_cyc >= 16), 64'h1);
    run_cmd(2'd2, 2'd0, 64'h5000, 64'h6666, 1'b0);
    run_cmd(2'd3, 2'd0, 64'h0, 64'h0, 1'b0);
    run_cmd(2'd1, 2'd3, 64'h0, 64'h0, 1'b0);
    chk("R7", "pop stall lengthens operation", 64'(last_cyc >= 16), 64'h1);
    ready_delay = 1; rsp_delay = 2;

    // R10: pops run SP below zero and wrap
    for (int i = 0; i < 9; i++) run_cmd(2'd1, 2'd3, 64'h0, 64'h0, 1'b0);
    chk("R10", "sp wrapped", sp, 64'hFFFFFFFFFFFFFFF8);
    run_cmd(2'd0, 2'd3, 64'h0102030405060708, 64'h0, 1'b0);
    chk("R10", "sp wraps back to zero", sp, 64'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R8 watchdog expired: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule